// File: doc/BRIEF.md
# Hybrid Majority Voter with Spare Replacement

This block takes a group of redundant bit sources, for example serial lines from replicated modules. Three of them form the active voting set, and the rest wait as spares. On every qualified sample the three voting members are combined by two-out-of-three majority. A member that disagrees with the majority on a programmable number of consecutive samples is marked failed and leaves the set. The lowest-numbered healthy spare then takes its place. With `N_LINES` sources the voter survives `N_LINES-2` member failures.

A newly selected member may carry stale state, so it does not vote until the surrounding system has loaded it to match the survivors. The block asks for that load with `load_req` and the line number. It waits for `load_ack` before the member counts. Until then the two survivors vote in compare mode. Once no spare remains and only two members are left, the voter stays in duplex compare mode for good. Any disagreement in that mode latches an unrecoverable-error flag. An alarm marks every sample on which fewer than two voting members agree with the result.

Top module: `hsv_spare_voter`

## Requirements
- R1: After reset, lines 0, 1 and 2 are active, no line is failed, and `load_req`, `vote_out`, `vote_vld`, `alarm`, `duplex_mode` and `unrecov_err` are all 0.
- R2: The cycle after a sample with `sample_vld`=1, `vote_vld` is 1. If three members vote, `vote_out` is 1 exactly when two or more of them are 1. With two voting members, `vote_out` follows the lower-numbered one.
- R3: A voting member is marked failed on the sample that makes its run of consecutive disagreements with a three-member majority reach `fail_thresh`. A value of 0 counts as 1. An agreeing sample clears the run.
- R4: A failed member is replaced by the lowest-numbered line that is neither active nor failed. Failed lines never become active again before reset. The active set always holds two or three lines and never includes a failed line.
- R5: A replacement raises `load_req` with its line number on `load_idx`. Both are held until `load_ack`. Until then the replacement is active but does not vote, and its bit has no effect on `vote_out`.
- R6: When no spare remains after a failure, `duplex_mode` is 1. A sample in that mode whose two members differ sets `unrecov_err`, which stays 1 until reset.
- R7: `alarm` is updated with `vote_vld`. It is 1 when fewer than two voting members match `vote_out`.
- R8: Samples with `sample_vld`=0 change nothing: `vote_out` and `alarm` hold, and disagreement runs and member state are untouched.
- R9: At most one member is retired per sample, and the failed set only grows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_vld | input | 1 | Qualifies `lines_in` for this cycle |
| lines_in | input | N_LINES | One bit from each redundant source |
| fail_thresh | input | TH_W | Consecutive disagreements that retire a member (0 acts as 1) |
| load_ack | input | 1 | Replacement state has been loaded |
| vote_out | output | 1 | Voted bit, registered |
| vote_vld | output | 1 | Pulses one cycle after each qualified sample |
| alarm | output | 1 | Fewer than two voting members agreed on the last sample |
| active_mask | output | N_LINES | Lines currently in the active set |
| failed_mask | output | N_LINES | Lines retired since reset |
| load_req | output | 1 | A replacement awaits state loading |
| load_idx | output | $clog2(N_LINES) | Line number of the pending replacement |
| duplex_mode | output | 1 | Only two members remain and no spare is left |
| unrecov_err | output | 1 | Sticky: the two duplex members disagreed |

## Verification
All eight three-member patterns are applied first, which separates majority from other ways of choosing the output and confirms that the spare line is ignored. A directed run breaks a disagreement streak with an agreeing sample and with unqualified samples. This tells the consecutive-run rule apart from a plain total, and it shows whether gaps without `sample_vld` are skipped. The run continues through a withheld load, where the replacement's bit conflicts with the survivors, and on into duplex mode with a disagreement. Seeded random traffic then injects persistent faults on one or two lines at random thresholds. Acknowledgements come at random times, so retirements, spare selection and alarms are compared against a bench model over many orderings.

// File: rtl/hsv_pkg.sv
`timescale 1ns/1ps
package hsv_pkg;
  localparam int MAX_LINES = 16;
  typedef logic [MAX_LINES-1:0] line_vec_t;
  typedef logic [4:0]           tally_t;

  // number of set bits in a widened line vector
  function automatic tally_t tally(input line_vec_t v);
    tally_t t;
    t = '0;
    for (int i = 0; i < MAX_LINES; i++) t = t + tally_t'(v[i]);
    return t;
  endfunction

  // position of the single set bit (0 when none)
  function automatic int onehot_idx(input line_vec_t v);
    int r;
    r = 0;
    for (int i = 0; i < MAX_LINES; i++) if (v[i]) r = i;
    return r;
  endfunction
endpackage

// File: rtl/hsv_vote_core.sv
`timescale 1ns/1ps
module hsv_vote_core import hsv_pkg::*; #(
  parameter int N_LINES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines,
  input  logic [N_LINES-1:0] vmask,
  output logic               vote,
  output logic [N_LINES-1:0] dissent,
  output logic               full_set,
  output logic               pair_set,
  output logic               weak_agree
);
  line_vec_t          vm_x, on_x, dis_x;
  tally_t             members, ones, agree;
  logic [N_LINES-1:0] lead_bit;
  logic               lead_val;

  assign lead_bit = vmask & (~vmask + 1'b1);
  assign lead_val = |(lead_bit & lines);

  always_comb begin
    vm_x = '0;
    on_x = '0;
    vm_x[N_LINES-1:0] = vmask;
    on_x[N_LINES-1:0] = vmask & lines;
    members = tally(vm_x);
    ones    = tally(on_x);
    vote    = (members == 5'd3) ? (ones >= 5'd2) : lead_val;
  end

  assign dissent = vmask & (lines ^ {N_LINES{vote}});

  always_comb begin
    dis_x = '0;
    dis_x[N_LINES-1:0] = dissent;
    agree = members - tally(dis_x);
  end

  assign full_set   = (members == 5'd3);
  assign pair_set   = (members == 5'd2);
  assign weak_agree = (agree < 5'd2);

  AST_SINGLE_DISSENT: assert property (@(posedge clk) disable iff (!rst_n)
    full_set |-> $countones(dissent) <= 1); // R2
endmodule

// File: rtl/hsv_miss_track.sv
`timescale 1ns/1ps
module hsv_miss_track #(
  parameter int N_LINES = 4,
  parameter int TH_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_vld,
  input  logic               full_set,
  input  logic [N_LINES-1:0] dissent,
  input  logic [TH_W-1:0]    thresh,
  output logic [N_LINES-1:0] retire
);
  logic [TH_W-1:0] eff_thresh;
  assign eff_thresh = (thresh == '0) ? TH_W'(1) : thresh;

  for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
    logic [TH_W-1:0] run_cnt;
    logic [TH_W:0]   run_nxt;
    logic            miss;

    assign miss        = sample_vld & full_set & dissent[gi];
    assign run_nxt     = {1'b0, run_cnt} + 1'b1;
    assign retire[gi]  = miss & (run_nxt >= {1'b0, eff_thresh});

    always_ff @(posedge clk) begin
      if (!rst_n)          run_cnt <= '0;
      else if (sample_vld) run_cnt <= (miss && !retire[gi]) ? run_nxt[TH_W-1:0] : '0;
    end

    AST_RUN_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt < eff_thresh || $changed(thresh) || $past(thresh) != thresh); // R3
  end

  AST_RETIRE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(retire)); // R9
endmodule

// File: rtl/hsv_spare_ctrl.sv
`timescale 1ns/1ps
module hsv_spare_ctrl import hsv_pkg::*; #(
  parameter int N_LINES = 4,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_vld,
  input  logic [N_LINES-1:0] retire,
  input  logic               load_ack,
  input  logic               pair_mismatch,
  output logic [N_LINES-1:0] active,
  output logic [N_LINES-1:0] failed,
  output logic [N_LINES-1:0] loading,
  output logic               load_req,
  output logic [IDX_W-1:0]   load_idx,
  output logic               duplex,
  output logic               unrecov
);
  localparam logic [N_LINES-1:0] INIT_ACT = N_LINES'(3'b111);

  logic [N_LINES-1:0] spare, pick;
  line_vec_t          act_x, load_x;

  assign spare = ~active & ~failed;
  assign pick  = spare & (~spare + 1'b1);

  always_comb begin
    act_x  = '0;
    load_x = '0;
    act_x[N_LINES-1:0]  = active;
    load_x[N_LINES-1:0] = loading;
  end

  assign duplex   = (tally(act_x) == 5'd2);
  assign load_req = |loading;
  assign load_idx = IDX_W'(onehot_idx(load_x));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= INIT_ACT;
      failed  <= '0;
      loading <= '0;
      unrecov <= 1'b0;
    end else begin
      if (retire != '0) begin
        failed  <= failed | retire;
        active  <= (active & ~retire) | pick;
        loading <= pick;
      end else if (load_ack) begin
        loading <= '0;
      end
      if (sample_vld && duplex && pair_mismatch) unrecov <= 1'b1;
    end
  end

  AST_FAILED_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (failed & active) == '0); // R4
  AST_ACTIVE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active) == 2 || $countones(active) == 3); // R4
  AST_FAILED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((failed & $past(failed)) == $past(failed))); // R9
  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !load_ack) |=> (load_req && $stable(load_idx))); // R5
  AST_UNRECOV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unrecov |=> unrecov); // R6
endmodule

// File: rtl/hsv_spare_voter.sv
`timescale 1ns/1ps
module hsv_spare_voter #(
  parameter int N_LINES = 4,
  parameter int TH_W    = 4,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_vld,
  input  logic [N_LINES-1:0] lines_in,
  input  logic [TH_W-1:0]    fail_thresh,
  input  logic               load_ack,
  output logic               vote_out,
  output logic               vote_vld,
  output logic               alarm,
  output logic [N_LINES-1:0] active_mask,
  output logic [N_LINES-1:0] failed_mask,
  output logic               load_req,
  output logic [IDX_W-1:0]   load_idx,
  output logic               duplex_mode,
  output logic               unrecov_err
);
  logic [N_LINES-1:0] vmask, dissent, retire, loading;
  logic               vote, full_set, pair_set, weak_agree, pair_mismatch;

  assign vmask         = active_mask & ~loading;
  assign pair_mismatch = pair_set & (dissent != '0);

  hsv_vote_core #(.N_LINES(N_LINES)) u_core (
    .clk(clk), .rst_n(rst_n), .lines(lines_in), .vmask(vmask),
    .vote(vote), .dissent(dissent), .full_set(full_set),
    .pair_set(pair_set), .weak_agree(weak_agree)
  );

  hsv_miss_track #(.N_LINES(N_LINES), .TH_W(TH_W)) u_track (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .full_set(full_set),
    .dissent(dissent), .thresh(fail_thresh), .retire(retire)
  );

  hsv_spare_ctrl #(.N_LINES(N_LINES)) u_spare (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .retire(retire),
    .load_ack(load_ack), .pair_mismatch(pair_mismatch),
    .active(active_mask), .failed(failed_mask), .loading(loading),
    .load_req(load_req), .load_idx(load_idx), .duplex(duplex_mode),
    .unrecov(unrecov_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vote_out <= 1'b0;
      vote_vld <= 1'b0;
      alarm    <= 1'b0;
    end else begin
      vote_vld <= sample_vld;
      if (sample_vld) begin
        vote_out <= vote;
        alarm    <= weak_agree;
      end
    end
  end

  AST_VLD_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    vote_vld |-> $past(sample_vld)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> ($stable(vote_out) && $stable(alarm))); // R8
  AST_LOADING_NOT_VOTING: assert property (@(posedge clk) disable iff (!rst_n)
    (loading & ~active_mask) == '0); // R5
endmodule

// File: tb/hsv_spare_voter_tb.sv
`timescale 1ns/1ps
module hsv_spare_voter_tb;
  localparam int N  = 4;
  localparam int TW = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n, sample_vld, load_ack;
  logic [N-1:0]  lines_in;
  logic [TW-1:0] fail_thresh;
  logic          vote_out, vote_vld, alarm, load_req, duplex_mode, unrecov_err;
  logic [N-1:0]  active_mask, failed_mask;
  logic [IW-1:0] load_idx;

  always #2 clk = ~clk;

  hsv_spare_voter #(.N_LINES(N), .TH_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .lines_in(lines_in),
    .fail_thresh(fail_thresh), .load_ack(load_ack), .vote_out(vote_out),
    .vote_vld(vote_vld), .alarm(alarm), .active_mask(active_mask),
    .failed_mask(failed_mask), .load_req(load_req), .load_idx(load_idx),
    .duplex_mode(duplex_mode), .unrecov_err(unrecov_err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit m_act[N];
  bit m_fail[N];
  int m_cnt[N];
  int m_load;
  bit m_unrec, e_vote, e_vld, e_alarm;
  int prev_failed;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int bits_of(input bit a[N]);
    int r = 0;
    for (int i = 0; i < N; i++) if (a[i]) r |= (1 << i);
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_act[i] = (i < 3); m_fail[i] = 0; m_cnt[i] = 0;
    end
    m_load = -1; m_unrec = 0; e_vote = 0; e_vld = 0; e_alarm = 0;
    prev_failed = 0;
  endtask

  task automatic model_step(input logic [N-1:0] ln, input bit vld, input bit ack, input int th);
    int voters[$];
    int ones, agree, lim, victim, nact;
    bit v;
    for (int i = 0; i < N; i++) if (m_act[i] && i != m_load) voters.push_back(i);
    ones = 0;
    foreach (voters[k]) ones += ln[voters[k]];
    if (voters.size() == 3)      v = (ones >= 2);
    else if (voters.size() > 0)  v = ln[voters[0]];
    else                         v = 0;
    e_vld = vld;
    victim = -1;
    if (vld) begin
      agree = 0;
      foreach (voters[k]) if (ln[voters[k]] == v) agree++;
      e_vote = v;
      e_alarm = (agree < 2);
      lim = (th == 0) ? 1 : th;
      for (int i = 0; i < N; i++) begin
        bit counted = 0;
        foreach (voters[k]) if (voters[k] == i && voters.size() == 3 && ln[i] != v) counted = 1;
        if (counted) begin
          if (m_cnt[i] + 1 >= lim) begin victim = i; m_cnt[i] = 0; end
          else m_cnt[i]++;
        end else m_cnt[i] = 0;
      end
      nact = 0;
      for (int i = 0; i < N; i++) nact += m_act[i];
      if (nact == 2 && voters.size() == 2 && ln[voters[0]] != ln[voters[1]]) m_unrec = 1;
    end
    if (victim >= 0) begin
      m_fail[victim] = 1; m_act[victim] = 0; m_load = -1;
      for (int j = 0; j < N; j++)
        if (!m_act[j] && !m_fail[j] && m_load < 0) begin m_act[j] = 1; m_load = j; end
    end else if (ack) m_load = -1;
  endtask

  task automatic compare_all();
    int nact = 0;
    int fb;
    for (int i = 0; i < N; i++) nact += m_act[i];
    fb = bits_of(m_fail);
    chk("R2", "vote_vld", vote_vld, e_vld);
    chk("R8", "vote_out", vote_out, e_vote);   // holds across idle cycles
    chk("R7", "alarm", alarm, e_alarm);
    chk("R4", "active_mask", active_mask, bits_of(m_act));
    chk("R3", "failed_mask", failed_mask, fb);
    chk("R9", "failed_sticky", int'(failed_mask) & prev_failed, prev_failed);
    chk("R5", "load_req", load_req, m_load >= 0);
    if (m_load >= 0) chk("R5", "load_idx", load_idx, m_load);
    chk("R6", "duplex_mode", duplex_mode, nact == 2);
    chk("R6", "unrecov_err", unrecov_err, m_unrec);
    prev_failed = int'(failed_mask);
  endtask

  // called at a falling edge; leaves at the next falling edge
  task automatic step(input logic [N-1:0] ln, input bit vld, input bit ack);
    lines_in = ln; sample_vld = vld; load_ack = ack;
    model_step(ln, vld, ack, int'(fail_thresh));
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset(input int th);
    rst_n = 0; sample_vld = 0; load_ack = 0; lines_in = '0;
    fail_thresh = TW'(th);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
    @(posedge clk);
    @(negedge clk);
    chk("R1", "active_mask", active_mask, 7);
    chk("R1", "failed_mask", failed_mask, 0);
    chk("R1", "load_req", load_req, 0);
    chk("R1", "vote_out", vote_out, 0);
    chk("R1", "vote_vld", vote_vld, 0);
    chk("R1", "alarm", alarm, 0);
    chk("R1", "duplex_mode", duplex_mode, 0);
    chk("R1", "unrecov_err", unrecov_err, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));

    // R2: every three-member pattern, spare line driven opposite
    do_reset(15);
    for (int p = 0; p < 8; p++) step({~p[0], p[2:0]}, 1, 0);

    // R3 + R8: streak broken by agreement, idle gaps skipped
    do_reset(3);
    step(4'b0010, 1, 0);
    step(4'b0010, 1, 0);
    for (int k = 0; k < 3; k++) step(4'b0010, 0, 0);
    step(4'b0000, 1, 0);
    step(4'b0010, 1, 0);
    step(4'b0010, 0, 0);
    step(4'b0010, 1, 0);
    step(4'b0010, 1, 0);      // third in a row: line 1 retires, line 3 loads
    // R5: replacement bit conflicts while load is pending
    for (int k = 0; k < 3; k++) step(4'b1000, 1, 0);
    step(4'b1101, 1, 0);
    step(4'b0000, 0, 1);
    step(4'b1000, 1, 0);
    // R6: retire line 0 with no spare left, then disagree in duplex
    fail_thresh = TW'(1);
    step(4'b0001, 1, 0);
    step(4'b1100, 1, 0);
    step(4'b0100, 1, 0);
    step(4'b1100, 1, 0);

    // R3: zero threshold retires on first disagreement
    do_reset(0);
    step(4'b0100, 1, 0);
    step(4'b1011, 1, 1);

    // seeded random traffic with persistent faults
    for (int s = 0; s < 8; s++) begin
      int bad1, bad2;
      do_reset(int'($urandom_range(0, 3)));
      bad1 = int'($urandom_range(0, N - 1));
      bad2 = int'($urandom_range(0, N - 1));
      for (int t = 0; t < 250; t++) begin
        logic [N-1:0] ln;
        bit base;
        base = bit'($urandom_range(0, 1));
        ln = {N{base}};
        for (int i = 0; i < N; i++) begin
          if ((i == bad1 || (i == bad2 && t > 100)) && $urandom_range(0, 9) < 6) ln[i] = ~ln[i];
          else if ($urandom_range(0, 99) < 3) ln[i] = ~ln[i];
        end
        step(ln, $urandom_range(0, 9) < 8, load_req && ($urandom_range(0, 9) < 3));
      end
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule